// File: doc/BRIEF.md
# I2C Master SCL Period Generator

This block produces the clock waveform that an I2C master drives on SCL. It holds two pairs of cycle counts, one pair for standard mode and one for fast mode, and a mode input picks which pair paces the clock. Each low phase is timed from the cycle the block starts pulling SCL low. Each high phase is timed only once the wire is actually sensed high. That start point absorbs the rise time and any clock stretching by a target device. The high phase always runs a fixed eight cycles longer than its programmed count.

The block drives an open-drain style pull-low request and takes back the sensed level of the wire. It emits a one-cycle strobe when a low phase begins and another when a counted high phase begins, so that the data sequencer can place its SDA changes and samples. Counts are loaded through a small write port that is only honoured while the generator is disabled. Written values below the legal minimum are raised to that minimum.

Top module: `sclgen_top`

## Requirements
- R1: While reset is held, and afterwards while `enable` is low, `scl_drive_low`, `fall_stb` and `rise_stb` are all 0. The reset counts pace the clock until they are overwritten.
- R2: Every low phase keeps `scl_drive_low` at 1 for exactly LCNT+1 consecutive cycles. The first low phase begins on the cycle after the clock edge that first samples `enable` high.
- R3: When SCL is sensed high in the first cycle after release, the released time is exactly HCNT+8 cycles before the next low phase begins.
- R4: Each released cycle in which `scl_in` is still sampled low delays the start of the high count by one cycle. Such a cycle lengthens the released time to S+HCNT+8 cycles, where S is the number of stretched cycles.
- R5: With `mode_fast`=0 the counts written at `cfg_sel`=0 (high) and `cfg_sel`=1 (low) are used. With `mode_fast`=1 the counts at `cfg_sel`=2 (high) and `cfg_sel`=3 (low) are used. The mode is taken whenever a phase count is loaded.
- R6: A written high count below 6 is stored as 6. A written low count below 8 is stored as 8.
- R7: A write while `enable` is 1 leaves the stored counts unchanged.
- R8: On the cycle after the clock edge that samples `enable` low, `scl_drive_low` is 0. It stays 0 while `enable` stays low.
- R9: `fall_stb` is 1 for exactly the first cycle of each low phase. `rise_stb` is 1 for exactly one cycle per released period: the cycle after the one in which SCL was first sampled high. The two strobes are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the generator when 1; releases SCL and unlocks writes when 0 |
| mode_fast | input | 1 | 0 selects standard-mode counts, 1 selects fast-mode counts |
| cfg_we | input | 1 | Count write strobe |
| cfg_sel | input | 2 | Count select: 0 std high, 1 std low, 2 fast high, 3 fast low |
| cfg_data | input | CNT_W | Count value to write |
| scl_in | input | 1 | Sensed SCL level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First cycle of a counted high phase |

## Verification
The bench builds the block with CNT_W=8. This keeps the largest count, 255, reachable in a few hundred cycles, so the all-ones count and the carry into the widened high counter are tried directly. Random trials draw counts from 0 to 40, so many land below the clamp floors of 6 and 8 and many land just above them. Each trial also draws a stretch length of up to 5 cycles. With the reset counts kept small, the reset pacing, the mode swap and the locked-write case all fit within a short run.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_REL  = 2'd2,
    PH_HIGH = 2'd3
  } phase_t;
endpackage

// File: rtl/sclgen_cfg.sv
module sclgen_cfg #(
  parameter int CNT_W    = 16,
  parameter int HI_MIN   = 6,
  parameter int LO_MIN   = 8,
  parameter int RST_SS_H = 40,
  parameter int RST_SS_L = 47,
  parameter int RST_FS_H = 6,
  parameter int RST_FS_L = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] data,
  input  logic             mode_fast,
  output logic [CNT_W-1:0] hcnt,
  output logic [CNT_W-1:0] lcnt
);
  localparam int NREG = 4;

  logic [CNT_W-1:0] cur [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'((i % 2 == 0) ? HI_MIN : LO_MIN);
    localparam logic [CNT_W-1:0] INIT  = CNT_W'((i == 0) ? RST_SS_H :
                                                  (i == 1) ? RST_SS_L :
                                                  (i == 2) ? RST_FS_H : RST_FS_L);
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= INIT;
      end else if (we && !lock && sel == 2'(i)) begin
        q <= (data < FLOOR) ? FLOOR : data;
      end
    end
    assign cur[i] = q;
  end

  assign hcnt = mode_fast ? cur[2] : cur[0];
  assign lcnt = mode_fast ? cur[3] : cur[1];
endmodule

// File: rtl/sclgen_phase.sv
module sclgen_phase
  import sclgen_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int HI_OVH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] hcnt,
  input  logic [CNT_W-1:0] lcnt,
  output logic             drive_low,
  output logic             fall_stb,
  output logic             rise_stb
);
  localparam int CW = CNT_W + 1;
  // the sensing cycle plus the counted cycles make up the overhead
  localparam logic [CW-1:0] HI_ADD = CW'(HI_OVH - 2);

  phase_t        ph_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      drive_low <= 1'b0;
      fall_stb  <= 1'b0;
      rise_stb  <= 1'b0;
    end else begin
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
      if (!enable) begin
        ph_q      <= PH_IDLE;
        drive_low <= 1'b0;
      end else begin
        unique case (ph_q)
          PH_IDLE: begin
            ph_q      <= PH_LOW;
            cnt_q     <= CW'(lcnt);
            drive_low <= 1'b1;
            fall_stb  <= 1'b1;
          end
          PH_LOW: begin
            if (cnt_q == '0) begin
              ph_q      <= PH_REL;
              drive_low <= 1'b0;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          PH_REL: begin
            if (scl_in) begin
              ph_q     <= PH_HIGH;
              cnt_q    <= CW'(hcnt) + HI_ADD;
              rise_stb <= 1'b1;
            end
          end
          PH_HIGH: begin
            if (cnt_q == '0) begin
              ph_q      <= PH_LOW;
              cnt_q     <= CW'(lcnt);
              drive_low <= 1'b1;
              fall_stb  <= 1'b1;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          default: ph_q <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sclgen_top.sv
module sclgen_top #(
  parameter int CNT_W    = 16,
  parameter int HI_OVH   = 8,
  parameter int HI_MIN   = 6,
  parameter int LO_MIN   = 8,
  parameter int RST_SS_H = 40,
  parameter int RST_SS_L = 47,
  parameter int RST_FS_H = 6,
  parameter int RST_FS_L = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             mode_fast,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CNT_W-1:0] cfg_data,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             fall_stb,
  output logic             rise_stb
);
  logic [CNT_W-1:0] hcnt_sel;
  logic [CNT_W-1:0] lcnt_sel;

  sclgen_cfg #(
    .CNT_W(CNT_W), .HI_MIN(HI_MIN), .LO_MIN(LO_MIN),
    .RST_SS_H(RST_SS_H), .RST_SS_L(RST_SS_L),
    .RST_FS_H(RST_FS_H), .RST_FS_L(RST_FS_L)
  ) u_cfg (
    .clk(clk), .rst(rst), .lock(enable), .we(cfg_we), .sel(cfg_sel),
    .data(cfg_data), .mode_fast(mode_fast), .hcnt(hcnt_sel), .lcnt(lcnt_sel)
  );

  sclgen_phase #(.CNT_W(CNT_W), .HI_OVH(HI_OVH)) u_phase (
    .clk(clk), .rst(rst), .enable(enable), .scl_in(scl_in),
    .hcnt(hcnt_sel), .lcnt(lcnt_sel),
    .drive_low(scl_drive_low), .fall_stb(fall_stb), .rise_stb(rise_stb)
  );
endmodule

// File: rtl/sclgen_chk.sv
module sclgen_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic scl_in,
  input logic scl_drive_low,
  input logic fall_stb,
  input logic rise_stb
);
  // R9
  fall_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_drive_low) |-> fall_stb);
  // R9
  fall_low_chk: assert property (@(posedge clk) disable iff (rst)
    fall_stb |-> (scl_drive_low && !$past(scl_drive_low)));
  // R9
  rise_sense_chk: assert property (@(posedge clk) disable iff (rst)
    rise_stb |-> (!scl_drive_low && $past(scl_in)));
  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fall_stb, rise_stb}));
  // R8
  disable_rel_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!scl_drive_low && !fall_stb && !rise_stb));
  // R4
  stretch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!scl_drive_low && !scl_in) |=> !rise_stb);
  // R2
  low_min_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && $rose(scl_drive_low)) |=> (scl_drive_low || !$past(enable)));
  // R3
  high_min_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_drive_low) |=> !scl_drive_low);
endmodule

bind sclgen_top sclgen_chk chk_i (
  .clk(clk), .rst(rst), .enable(enable), .scl_in(scl_in),
  .scl_drive_low(scl_drive_low), .fall_stb(fall_stb), .rise_stb(rise_stb)
);

// File: tb/sclgen_tb.sv
module sclgen_top_tb_top;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic mode_fast = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [CNT_W-1:0] cfg_data = '0;
  logic hold_low = 1'b0;
  logic scl_in;
  logic scl_drive_low, fall_stb, rise_stb;

  assign scl_in = ~scl_drive_low & ~hold_low;

  always #10 clk = ~clk;

  sclgen_top #(.CNT_W(CNT_W), .RST_SS_H(10), .RST_SS_L(12),
               .RST_FS_H(6), .RST_FS_L(9)) dut_i (
    .clk(clk), .rst(rst), .enable(enable), .mode_fast(mode_fast),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  int total = 0;
  int bad = 0;
  bit wd = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_low(input int l);
    return ((l < 8) ? 8 : l) + 1;
  endfunction
  function automatic int exp_high(input int h, input int s);
    return s + ((h < 6) ? 6 : h) + 8;
  endfunction

  // run monitor, sampled at negedge
  logic prev_drv = 1'b0;
  int run_len = 0;
  int rise_in_run = 0;
  int last_low = 0, last_high = 0, last_rise = 0;
  int low_runs = 0, high_runs = 0;
  int stretch_n = 0;
  int fall_ok_bad = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (scl_drive_low != prev_drv) begin
        if (prev_drv) begin
          last_low = run_len; low_runs++;
        end else begin
          last_high = run_len; last_rise = rise_in_run; high_runs++;
        end
        if (scl_drive_low && !fall_stb) fall_ok_bad++;
        run_len = 1;
        rise_in_run = 0;
      end else begin
        run_len++;
      end
      if (rise_stb) rise_in_run++;
      prev_drv = scl_drive_low;
      hold_low = !scl_drive_low && enable && (run_len <= stretch_n);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    wd = 1'b1;
  end

  task automatic wr(input logic [1:0] sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = CNT_W'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_and_check(input int h, input int l, input int s, input string req);
    int hr0;
    stretch_n = s;
    @(negedge clk);
    enable = 1'b1;
    hr0 = high_runs;
    while (high_runs < hr0 + 3 && !wd) @(negedge clk);
    chk(last_low == exp_low(l), {req, " low"}, last_low, exp_low(l));
    chk(last_high == exp_high(h, s), {req, " high"}, last_high, exp_high(h, s));
    chk(last_rise == 1, "R9 rise count", last_rise, 1);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    process_main();
  end

  task automatic process_main();
    int h, l, s;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(scl_drive_low == 0 && fall_stb == 0 && rise_stb == 0, "R1 reset outputs",
        {scl_drive_low, fall_stb, rise_stb}, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(scl_drive_low == 0, "R1 idle released", scl_drive_low, 0);

    // R1 reset counts, standard mode; R2 first low starts after enable edge
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    chk(scl_drive_low == 1 && fall_stb == 1, "R2 first low start",
        {scl_drive_low, fall_stb}, 3);
    @(negedge clk); enable = 1'b0; @(negedge clk); @(negedge clk);
    run_and_check(10, 12, 0, "R1 reset std");
    mode_fast = 1'b1;
    run_and_check(6, 9, 0, "R1 reset fast");

    // R5 mode selection with distinct pairs
    wr(2'd0, 20); wr(2'd1, 25); wr(2'd2, 7); wr(2'd3, 11);
    mode_fast = 1'b0;
    run_and_check(20, 25, 0, "R5 std pair");
    mode_fast = 1'b1;
    run_and_check(7, 11, 0, "R5 fast pair");

    // R6 clamp at zero and just below floors
    wr(2'd2, 0); wr(2'd3, 0);
    run_and_check(0, 0, 0, "R6 clamp zero");
    wr(2'd2, 5); wr(2'd3, 7);
    run_and_check(5, 7, 0, "R6 clamp below");

    // R3 maximum counts
    wr(2'd2, 255); wr(2'd3, 255);
    run_and_check(255, 255, 0, "R3 max count");

    // R4 stretching
    wr(2'd2, 9); wr(2'd3, 10);
    run_and_check(9, 10, 4, "R4 stretch");

    // R7 write while enabled ignored
    stretch_n = 0;
    @(negedge clk); enable = 1'b1;
    repeat (5) @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd2; cfg_data = 8'd30;
    @(negedge clk);
    cfg_sel = 2'd3;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk); enable = 1'b0; @(negedge clk); @(negedge clk);
    run_and_check(9, 10, 0, "R7 locked write");

    // R8 disable mid low phase
    @(negedge clk); enable = 1'b1;
    repeat (4) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(scl_drive_low == 0, "R8 release after disable", scl_drive_low, 0);
    repeat (6) @(negedge clk);
    chk(scl_drive_low == 0 && fall_ok_bad == 0, "R8 stays released",
        scl_drive_low, 0);

    // random trials: R2 R3 R4 R5 R6
    for (int t = 0; t < 30 && !wd; t++) begin
      h = int'($urandom_range(0, 40));
      l = int'($urandom_range(0, 40));
      s = int'($urandom_range(0, 5));
      mode_fast = $urandom_range(0, 1);
      wr(mode_fast ? 2'd2 : 2'd0, h);
      wr(mode_fast ? 2'd3 : 2'd1, l);
      run_and_check(h, l, s, "R2 R3 R4 R5 R6 random");
    end

    chk(fall_ok_bad == 0, "R9 fall strobe", fall_ok_bad, 0);
    if (wd) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask
endmodule